// File: doc/BRIEF.md
# Pipelined SDRAM Burst Read Path

This block models the device side of a two-bank pipelined SDRAM read path. Each clock it samples a command slot that holds either a READ or a NOP, together with a bank and a column. A READ starts a four-word burst. The first word leaves on the data bus a configurable number of clocks after the command edge, which is the CAS latency of 1, 2 or 3. The following words come out on the next three clocks. A valid flag goes high on exactly the clocks that carry read data, and the bus is driven to zero on every other clock.

Commands pass through a fixed three-stage pipeline, and the configured latency picks which stage feeds the burst counter. Because of this, a READ may arrive on any clock, including in the middle of a burst that is still running. The newer command takes over the bus at its own latency and cuts the older burst short, so the data stream has no gaps and needs no alignment rule. Column addresses wrap inside the aligned group of four that holds the start column. The words come from a small register file indexed by bank and column, which a preload port fills.

Top module: `sdram_rd_pipe`

## Requirements
- R1: Take a READ sampled at rising edge e with latency setting L (input code 1, 2 or 3). Its first word, `mem[bank][col]`, is on `rd_data` with `rd_valid` high right after edge e+L.
- R2: A READ that no later command interrupts yields four words on four consecutive clocks, after edges e+L to e+L+3.
- R3: Word k of a burst (k = 0..3) comes from column `{col[COL_W-1:2], col[1:0]+k}` with the low two bits wrapping. For example, start column 2 gives columns 2, 3, 0, 1.
- R4: READs issued every fourth clock give an unbroken stream. The first word of each burst directly follows the last word of the one before it.
- R5: A READ sampled at edge e+j, with 1 ≤ j ≤ 3, after a READ at edge e ends the older burst. From edge e+j+L onward the bus carries the newer burst, and the remaining older words never appear.
- R6: Each READ may address either bank. Random columns within one bank are read at full rate.
- R7: `rd_valid` is high exactly on clocks that carry read data. While it is low, `rd_data` is zero.
- R8: A preload write (`pre_wr` high at an edge) updates the addressed word for every later read. It causes no output activity itself.
- R9: A synchronous active-low reset clears the command pipeline and the burst state. After an edge with `rst_n` low, `rd_valid` is low and no word of an aborted burst appears later.
- R10: The latency setting is static. It may change only while no READ is outstanding, and the output stays quiet across such a change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_cas_lat | input | 2 | Static CAS latency setting, legal values 1 to 3 |
| cmd_read | input | 1 | 1 = READ in this slot, 0 = NOP |
| cmd_bank | input | BANK_W (1) | Bank addressed by the READ |
| cmd_col | input | COL_W (4) | Start column of the READ |
| pre_wr | input | 1 | Preload write strobe |
| pre_bank | input | BANK_W (1) | Preload bank |
| pre_col | input | COL_W (4) | Preload column |
| pre_data | input | DATA_W (16) | Preload word |
| rd_data | output | DATA_W (16) | Read data bus, zero when idle |
| rd_valid | output | 1 | High on clocks that carry read data |

## Verification
Every result follows from the edge at which a READ is sampled. Word k of that READ is due right after edge e+L+k, unless a newer READ has reached its own edge e'+L by then, in which case the newer READ owns the bus. The bench drives each command half a cycle before its edge and samples the bus at the following falling edge. For every sampled clock it searches its command log backwards over exactly L to L+3 edges and treats the most recent hit as the owner of the bus. A reset edge empties that log, so the bench expects the bus to stay idle until a fresh READ matures.

// File: rtl/sdram_rd_pkg.sv
// Package: shared constants and types for the SDRAM burst read path.
// Assumes a fixed burst of four and a command pipeline of three stages.
package sdram_rd_pkg;
    localparam int BURST_LEN   = 4;
    localparam int BEAT_W      = $clog2(BURST_LEN);
    localparam int PIPE_STAGES = 3;
    localparam int LAT_W       = $clog2(PIPE_STAGES + 1);

    // Latency setting codes as they appear on the configuration input.
    typedef enum logic [LAT_W-1:0] {
        LAT_ILLEGAL = 2'd0,
        LAT_ONE     = 2'd1,
        LAT_TWO     = 2'd2,
        LAT_THREE   = 2'd3
    } lat_code_e;
endpackage

// File: rtl/sdram_rd_cmd_pipe.sv
// Module: command delay line. Each READ slot moves one stage per clock.
// The latency setting picks the stage that feeds the burst counter, so a
// READ sampled at edge e is presented on the tap after edge e+L-1.
// Assumes the setting changes only while every stage is empty.
module sdram_rd_cmd_pipe
    import sdram_rd_pkg::*;
#(
    parameter int BANK_W = 1,
    parameter int COL_W  = 4,
    parameter int DEPTH  = PIPE_STAGES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LAT_W-1:0]  cfg_lat,
    input  logic              in_vld,
    input  logic [BANK_W-1:0] in_bank,
    input  logic [COL_W-1:0]  in_col,
    output logic              tap_vld,
    output logic [BANK_W-1:0] tap_bank,
    output logic [COL_W-1:0]  tap_col
);
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [DEPTH-1:0]             stg_vld;
    logic [DEPTH-1:0][BANK_W-1:0] stg_bank;
    logic [DEPTH-1:0][COL_W-1:0]  stg_col;
    logic [IDX_W-1:0]             tap_idx;

    // Shift every stage forward one position; reset empties only the valid bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stg_vld <= '0;
        end else begin
            stg_vld[0] <= in_vld;
            for (int s = 1; s < DEPTH; s++) begin
                stg_vld[s] <= stg_vld[s-1];
            end
        end
        stg_bank[0] <= in_bank;
        stg_col[0]  <= in_col;
        for (int s = 1; s < DEPTH; s++) begin
            stg_bank[s] <= stg_bank[s-1];
            stg_col[s]  <= stg_col[s-1];
        end
    end

    // Map the latency code to a stage index, with an illegal zero clamped to the first stage.
    always_comb begin
        if (cfg_lat == LAT_ILLEGAL) begin
            tap_idx = '0;
        end else if (int'(cfg_lat) > DEPTH) begin
            tap_idx = IDX_W'(DEPTH - 1);
        end else begin
            tap_idx = IDX_W'(cfg_lat - 1'b1);
        end
    end

    // Present the selected stage to the burst counter.
    always_comb begin
        tap_vld  = stg_vld[tap_idx];
        tap_bank = stg_bank[tap_idx];
        tap_col  = stg_col[tap_idx];
    end
endmodule

// File: rtl/sdram_rd_burst_ctr.sv
// Module: burst counter. When the tap shows a READ, it starts (or restarts)
// a four-beat burst at once. Otherwise it steps through the remaining beats
// of the current burst. It gives the address of the word due at the next
// edge, so the output register catches that word at edge e+L+k.
// Assumes the beat count is a power of two, so the in-group wrap is free.
module sdram_rd_burst_ctr
    import sdram_rd_pkg::*;
#(
    parameter int BANK_W = 1,
    parameter int COL_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tap_vld,
    input  logic [BANK_W-1:0] tap_bank,
    input  logic [COL_W-1:0]  tap_col,
    output logic              beat_vld,
    output logic [BANK_W-1:0] beat_bank,
    output logic [COL_W-1:0]  beat_col
);
    localparam int GRP_W = COL_W - BEAT_W;

    logic              busy_q;
    logic [BANK_W-1:0] bank_q;
    logic [COL_W-1:0]  start_q;
    logic [BEAT_W-1:0] beat_q;
    logic [BEAT_W-1:0] low_sum;

    // Low column bits of the running burst: start offset plus beat, wrapping in the group.
    assign low_sum = start_q[BEAT_W-1:0] + beat_q;

    // Pick the word for the next edge; a matured READ overrides the running burst.
    always_comb begin
        if (tap_vld) begin
            beat_vld  = 1'b1;
            beat_bank = tap_bank;
            beat_col  = tap_col;
        end else if (busy_q) begin
            beat_vld  = 1'b1;
            beat_bank = bank_q;
            beat_col  = {start_q[COL_W-1 -: GRP_W], low_sum};
        end else begin
            beat_vld  = 1'b0;
            beat_bank = bank_q;
            beat_col  = start_q;
        end
    end

    // Track the burst in progress: restart on a new READ, finish after the last beat.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q  <= 1'b0;
            bank_q  <= '0;
            start_q <= '0;
            beat_q  <= '0;
        end else if (tap_vld) begin
            busy_q  <= 1'b1;
            bank_q  <= tap_bank;
            start_q <= tap_col;
            beat_q  <= BEAT_W'(1);
        end else if (busy_q) begin
            busy_q <= (beat_q != BEAT_W'(BURST_LEN - 1));
            beat_q <= beat_q + 1'b1;
        end
    end
endmodule

// File: rtl/sdram_rd_array.sv
// Module: register-file storage with one synchronous write port (preload)
// and one combinational read port. Each bank is a separate array built by
// a generate loop. The storage has no reset: its contents are defined only
// once preloaded.
module sdram_rd_array #(
    parameter int BANK_N = 2,
    parameter int BANK_W = 1,
    parameter int COL_W  = 4,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [BANK_W-1:0] wr_bank,
    input  logic [COL_W-1:0]  wr_col,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [BANK_W-1:0] rd_bank,
    input  logic [COL_W-1:0]  rd_col,
    output logic [DATA_W-1:0] rd_word
);
    localparam int COLS = 1 << COL_W;

    logic [BANK_N-1:0][DATA_W-1:0] bank_word;

    for (genvar b = 0; b < BANK_N; b++) begin : g_bank
        logic [DATA_W-1:0] cells [COLS];

        // Write the preload word when this bank is addressed.
        always_ff @(posedge clk) begin
            if (wr_en && (wr_bank == BANK_W'(b))) begin
                cells[wr_col] <= wr_data;
            end
        end

        // Read this bank at the requested column.
        assign bank_word[b] = cells[rd_col];
    end

    // Choose the addressed bank's word.
    always_comb begin
        rd_word = '0;
        for (int b = 0; b < BANK_N; b++) begin
            if (rd_bank == BANK_W'(b)) begin
                rd_word = bank_word[b];
            end
        end
    end
endmodule

// File: rtl/sdram_rd_out_reg.sv
// Module: output register. It catches the addressed word together with its
// valid flag and forces the bus to zero on clocks that carry no data.
module sdram_rd_out_reg #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_vld,
    input  logic [DATA_W-1:0] in_word,
    output logic              out_vld,
    output logic [DATA_W-1:0] out_word
);
    // Register one beat; idle beats leave a zero bus.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_vld  <= 1'b0;
            out_word <= '0;
        end else begin
            out_vld  <= in_vld;
            out_word <= in_vld ? in_word : '0;
        end
    end
endmodule

// File: rtl/sdram_rd_pipe.sv
// Module: top of the SDRAM burst read path. Chain: command delay line ->
// burst counter -> storage read -> output register. A READ sampled at edge
// e shows its first word right after edge e+L. The latency input must be
// 1..3 and must be held constant while any READ is in flight.
module sdram_rd_pipe
    import sdram_rd_pkg::*;
#(
    parameter int BANK_N = 2,
    parameter int COL_W  = 4,
    parameter int DATA_W = 16,
    localparam int BANK_W = $clog2(BANK_N)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        cfg_cas_lat,
    input  logic              cmd_read,
    input  logic [BANK_W-1:0] cmd_bank,
    input  logic [COL_W-1:0]  cmd_col,
    input  logic              pre_wr,
    input  logic [BANK_W-1:0] pre_bank,
    input  logic [COL_W-1:0]  pre_col,
    input  logic [DATA_W-1:0] pre_data,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid
);
    logic              tap_vld;
    logic [BANK_W-1:0] tap_bank;
    logic [COL_W-1:0]  tap_col;
    logic              beat_vld;
    logic [BANK_W-1:0] beat_bank;
    logic [COL_W-1:0]  beat_col;
    logic [DATA_W-1:0] arr_word;

    sdram_rd_cmd_pipe #(
        .BANK_W (BANK_W),
        .COL_W  (COL_W),
        .DEPTH  (PIPE_STAGES)
    ) u_cmd_pipe (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_lat  (LAT_W'(cfg_cas_lat)),
        .in_vld   (cmd_read),
        .in_bank  (cmd_bank),
        .in_col   (cmd_col),
        .tap_vld  (tap_vld),
        .tap_bank (tap_bank),
        .tap_col  (tap_col)
    );

    sdram_rd_burst_ctr #(
        .BANK_W (BANK_W),
        .COL_W  (COL_W)
    ) u_burst (
        .clk       (clk),
        .rst_n     (rst_n),
        .tap_vld   (tap_vld),
        .tap_bank  (tap_bank),
        .tap_col   (tap_col),
        .beat_vld  (beat_vld),
        .beat_bank (beat_bank),
        .beat_col  (beat_col)
    );

    sdram_rd_array #(
        .BANK_N (BANK_N),
        .BANK_W (BANK_W),
        .COL_W  (COL_W),
        .DATA_W (DATA_W)
    ) u_array (
        .clk     (clk),
        .wr_en   (pre_wr),
        .wr_bank (pre_bank),
        .wr_col  (pre_col),
        .wr_data (pre_data),
        .rd_bank (beat_bank),
        .rd_col  (beat_col),
        .rd_word (arr_word)
    );

    sdram_rd_out_reg #(
        .DATA_W (DATA_W)
    ) u_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_vld   (beat_vld),
        .in_word  (arr_word),
        .out_vld  (rd_valid),
        .out_word (rd_data)
    );
endmodule

// File: rtl/sdram_rd_pipe_chk.sv
// Checker: port-level timing properties of the read path. It keeps a short
// log of sampled READ slots and relates rd_valid to that log.
module sdram_rd_pipe_chk
    import sdram_rd_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        cfg_cas_lat,
    input logic              cmd_read,
    input logic [DATA_W-1:0] rd_data,
    input logic              rd_valid
);
    localparam int HIST_W = PIPE_STAGES + BURST_LEN;

    logic [HIST_W-1:0] rd_log;
    logic [HIST_W-1:0] rd_aged;
    logic              in_window;

    // Log READ slots; bit k is the READ sampled k edges before the latest one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_log <= '0;
        end else begin
            rd_log <= {rd_log[HIST_W-2:0], cmd_read};
        end
    end

    // Some READ between L and L+3 edges old means data must be on the bus.
    assign rd_aged   = rd_log >> cfg_cas_lat;
    assign in_window = |rd_aged[BURST_LEN-1:0];

    // R7: valid exactly on data clocks.
    assert_valid_window_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid == in_window);

    // R7: idle bus is zero.
    assert_idle_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_valid |-> (rd_data == '0));

    // R1: first word after the selected latency, one property per setting.
    assert_lat1_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_read && cfg_cas_lat == 2'd1) |-> ##2 rd_valid);
    assert_lat2_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_read && cfg_cas_lat == 2'd2) |-> ##3 rd_valid);
    assert_lat3_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_read && cfg_cas_lat == 2'd3) |-> ##4 rd_valid);

    // R1: the latency code stays in its legal range.
    assert_lat_legal_R1: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_cas_lat != 2'd0);

    // R10: no latency change while a READ is logged.
    assert_lat_static_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (|rd_log) |-> $stable(cfg_cas_lat));

    // R9: a reset edge leaves the bus idle.
    assert_reset_idle_R9: assert property (@(posedge clk)
        !rst_n |=> !rd_valid);
endmodule

bind sdram_rd_pipe sdram_rd_pipe_chk #(.DATA_W(DATA_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_cas_lat (cfg_cas_lat),
    .cmd_read    (cmd_read),
    .rd_data     (rd_data),
    .rd_valid    (rd_valid)
);

// File: tb/sdram_rd_pipe_tb.sv
// Bench: sweeps every latency setting over single reads to all addresses,
// gapless streams, truncating command spacings, same-bank random reads,
// preload overwrite and reset during a burst. Expected words come from a
// log of commands and a bench copy of the preloaded contents.
module sdram_rd_pipe_tb;
    localparam int BANK_N = 2;
    localparam int BANK_W = 1;
    localparam int COL_W  = 4;
    localparam int DATA_W = 16;
    localparam int COLS   = 1 << COL_W;
    localparam int MAXC   = 8192;

    logic              clk = 1'b0;
    logic              rst_n;
    logic [1:0]        cfg_cas_lat;
    logic              cmd_read;
    logic [BANK_W-1:0] cmd_bank;
    logic [COL_W-1:0]  cmd_col;
    logic              pre_wr;
    logic [BANK_W-1:0] pre_bank;
    logic [COL_W-1:0]  pre_col;
    logic [DATA_W-1:0] pre_data;
    logic [DATA_W-1:0] rd_data;
    logic              rd_valid;

    int    n_chk  = 0;
    int    n_fail = 0;
    int    cyc    = 0;
    int    base   = 0;
    string cur_req = "R9";
    logic [7:0] lf = 8'h5B;

    logic              log_rd   [MAXC];
    int                log_bank [MAXC];
    int                log_col  [MAXC];
    logic              log_rst  [MAXC];
    logic [DATA_W-1:0] ref_mem  [BANK_N*COLS];

    always #5 clk = ~clk;

    sdram_rd_pipe #(
        .BANK_N (BANK_N),
        .COL_W  (COL_W),
        .DATA_W (DATA_W)
    ) u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_cas_lat (cfg_cas_lat),
        .cmd_read    (cmd_read),
        .cmd_bank    (cmd_bank),
        .cmd_col     (cmd_col),
        .pre_wr      (pre_wr),
        .pre_bank    (pre_bank),
        .pre_col     (pre_col),
        .pre_data    (pre_data),
        .rd_data     (rd_data),
        .rd_valid    (rd_valid)
    );

    function automatic logic [DATA_W-1:0] pattern(input int b, input int c);
        return DATA_W'((b * 256 + c * 17) ^ 32'h3C00);
    endfunction

    function automatic void lf_step();
        lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
    endfunction

    task automatic report();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    // Compare the bus after edge t with the owner found in the command log.
    task automatic check_out(input int t);
        logic              ev = 1'b0;
        logic [DATA_W-1:0] ed = '0;
        string             tag;
        int                lat = int'(cfg_cas_lat);
        int                w = 0;
        int                sc = 0;
        if (log_rst[t]) begin
            base = t + 1;
        end else begin
            for (int k = lat; k <= lat + 3; k++) begin
                if (!ev && (t - k) >= base && log_rd[t - k]) begin
                    ev = 1'b1;
                    w  = k - lat;
                    sc = log_col[t - k];
                    ed = ref_mem[log_bank[t - k] * COLS
                                 + ((sc & ~3) | ((sc + w) & 3))];
                end
            end
        end
        if (!ev) tag = log_rst[t] ? "R9" : (cur_req == "R10" ? "R10" : "R7");
        else if (cur_req == "R1") tag = (w == 0) ? "R1" : (((sc & 3) + w > 3) ? "R3" : "R2");
        else tag = cur_req;
        n_chk++;
        if (rd_valid !== ev) begin
            n_fail++;
            $display("FAIL %s cycle %0d rd_valid actual %0b expected %0b", tag, t, rd_valid, ev);
        end
        n_chk++;
        if (rd_data !== ed) begin
            n_fail++;
            $display("FAIL %s cycle %0d rd_data actual %h expected %h", tag, t, rd_data, ed);
        end
    endtask

    // Drive one command slot, pass the edge, then check at the falling edge.
    task automatic tick(input logic rd, input int b, input int c);
        cmd_read     = rd;
        cmd_bank     = BANK_W'(b);
        cmd_col      = COL_W'(c);
        log_rd[cyc]   = rd;
        log_bank[cyc] = b;
        log_col[cyc]  = c;
        log_rst[cyc]  = !rst_n;
        @(posedge clk);
        @(negedge clk);
        check_out(cyc);
        cyc++;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) tick(1'b0, 0, 0);
    endtask

    task automatic preload(input int b, input int c, input logic [DATA_W-1:0] d);
        pre_wr   = 1'b1;
        pre_bank = BANK_W'(b);
        pre_col  = COL_W'(c);
        pre_data = d;
        ref_mem[b * COLS + c] = d;
        tick(1'b0, 0, 0);
        pre_wr = 1'b0;
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL R4 watchdog expired actual running expected finished");
        report();
        $finish;
    end

    initial begin
        rst_n       = 1'b0;
        cfg_cas_lat = 2'd1;
        cmd_read    = 1'b0;
        cmd_bank    = '0;
        cmd_col     = '0;
        pre_wr      = 1'b0;
        pre_bank    = '0;
        pre_col     = '0;
        pre_data    = '0;
        @(negedge clk);

        // R9: reset state.
        cur_req = "R9";
        idle(3);
        rst_n = 1'b1;

        // R8: preload all words; preload makes no output activity.
        cur_req = "R8";
        for (int b = 0; b < BANK_N; b++)
            for (int c = 0; c < COLS; c++) preload(b, c, pattern(b, c));

        for (int lat = 1; lat <= 3; lat++) begin
            // R10: latency changed only while idle; bus stays quiet.
            cfg_cas_lat = 2'(lat);
            cur_req = "R10";
            idle(8);

            // R1 R2 R3: lone READ to every address.
            cur_req = "R1";
            for (int b = 0; b < BANK_N; b++)
                for (int c = 0; c < COLS; c++) begin
                    tick(1'b1, b, c);
                    idle(7);
                end

            // R4: gapless stream, READ every fourth clock, banks alternating.
            cur_req = "R4";
            for (int i = 0; i < 16; i++) begin
                lf_step();
                tick(1'b1, i % 2, int'(lf[3:0]));
                idle(3);
            end
            idle(8);

            // R5: truncation with spacings of 1, 2 and 3 clocks.
            cur_req = "R5";
            for (int gap = 1; gap <= 3; gap++) begin
                for (int i = 0; i < 12; i++) begin
                    lf_step();
                    tick(1'b1, int'(lf[4]), int'(lf[3:0]));
                    idle(gap - 1);
                end
                idle(8);
            end

            // R6: random columns in one bank, random spacings.
            cur_req = "R6";
            for (int i = 0; i < 24; i++) begin
                lf_step();
                tick(1'b1, 0, int'(lf[3:0]));
                idle(int'(lf[6:4]) % 6);
            end
            idle(8);
        end

        // R8: overwrite one word, then read the group that holds it.
        cur_req = "R8";
        preload(1, 5, 16'hBEEF);
        tick(1'b1, 1, 4);
        idle(8);

        // R9: reset during a burst aborts it.
        cur_req = "R9";
        tick(1'b1, 0, 8);
        idle(int'(cfg_cas_lat) + 1);
        rst_n = 1'b0;
        idle(1);
        rst_n = 1'b1;
        idle(8);
        tick(1'b1, 0, 9);
        idle(8);

        report();
        $finish;
    end
endmodule